// File: doc/BRIEF.md
# Linear Frequency Sweep Generator

This block produces a frequency tuning word that ramps in equal steps from a start word toward an end word. A programmable ramp-rate timer sets how often a step happens. On each expiry, the delta word is added to a sweep accumulator that holds the offset from the start word. The output word is the start word plus that offset. A direction pin chooses whether the offset climbs toward the end word or falls back toward the start word.

When the climb reaches the end word, one of two things happens:
- **Dwell mode:** the sweep holds at the end word, with the done flag high.
- **No-dwell mode:** the sweep jumps straight back to the start word, and the done flag pulses for one cycle.

An update strobe has two optional effects:
- It can reload the ramp-rate timer, which restarts the step schedule.
- It can zero the accumulator for one cycle.

A separate asynchronous clear input forces the accumulator to zero for as long as it is held.

Top module: `fsweep_gen`

## Requirements
- R1: While `rst` is high, the next clock edge drives `ftw` to 0 and `done` to 0.
- R2: While `sweep_en` is low, every clock edge loads `ftw` with `start_word` and `done` with 0. `no_dwell` has no effect in this state.
- R3: With `sweep_en` high and an effective rate value r, a step occurs on the r-th edge with `sweep_en` high, and then on every r-th edge after it. Each step changes the offset by `delta_word`, and `ftw` shows the new value at that same edge.
- R4: A `rate_reload` of 0 behaves as 1, which gives one step on every edge.
- R5: With `no_dwell` low and `sweep_up` high, a step that would reach or pass `end_word` leaves `ftw` at `end_word`. `done` is 1 on every edge where `ftw` equals `end_word`.
- R6: With `no_dwell` high and `sweep_up` high, a step that would reach or pass `end_word` sets `ftw` to `start_word` and `done` to 1 for that single edge. Sweeping then continues from the start word.
- R7: With `load_on_upd` low, an `upd` strobe leaves the step schedule unchanged.
- R8: With `load_on_upd` high, an `upd` strobe sampled at edge U reloads the timer. The next step then occurs at edge U+r.
- R9: With `autoclr` high, an `upd` strobe zeroes the offset at that edge, so `ftw` equals `start_word`, and stepping resumes afterwards. With `autoclr` low, the strobe leaves the offset unchanged.
- R10: While `acc_clr` is high, the offset is held at zero asynchronously, and every edge shows `ftw` equal to `start_word`. After release, stepping resumes from the start word.
- R11: With `sweep_up` low, each step subtracts `delta_word` from the offset. The subtraction saturates at zero, which is the start word.
- R12: The offset addition is done with one extra carry bit. `ftw` therefore never wraps past `end_word`, even when `delta_word` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_clr | input | 1 | Asynchronous accumulator clear, held while high |
| start_word | input | 32 | Sweep start tuning word |
| end_word | input | 32 | Sweep end tuning word |
| delta_word | input | 32 | Step size |
| rate_reload | input | 8 | Ramp-rate timer reload value (0 acts as 1) |
| sweep_en | input | 1 | Sweep enable |
| no_dwell | input | 1 | Return to start instead of holding at end |
| load_on_upd | input | 1 | Reload ramp timer on update strobe |
| autoclr | input | 1 | Zero accumulator for one cycle on update strobe |
| sweep_up | input | 1 | Direction: 1 climbs toward end, 0 falls toward start |
| upd | input | 1 | Update strobe, one cycle |
| ftw | output | 32 | Current tuning word (registered) |
| done | output | 1 | Sweep end flag (registered) |

## Verification
The design has no extra pipeline stage. Each registered output takes its value at the edge where the timer expires, the strobe is sampled, or the clear is seen. A step that the timer fires at edge k therefore appears on `ftw` right after edge k. With the timer reloaded at edge U, the next step appears right after edge U+r.

The bench drives inputs and samples outputs 1 ns after each rising edge. It counts edges from the one where the enable or strobe is first sampled, and compares each value against a schedule derived from r and the delta word.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;
  // what the accumulator does on a given edge
  typedef enum logic [2:0] {
    ACC_HOLD,
    ACC_ZERO,
    ACC_ADD,
    ACC_SAT,
    ACC_WRAP,
    ACC_SUB
  } acc_op_e;

  // effective reload: a zero value behaves as one
  function automatic logic [7:0] eff_rate8(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction
endpackage

// File: rtl/fsweep_rate_timer.sv
module fsweep_rate_timer #(
  parameter int RR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [RR_W-1:0] reload_val,
  input  logic            upd_load,
  output logic            tick
);
  localparam logic [RR_W-1:0] ONE = RR_W'(1);

  logic [RR_W-1:0] cnt;
  logic [RR_W-1:0] eff;

  assign eff  = (reload_val == '0) ? ONE : reload_val;
  // timeout when the count has reached one
  assign tick = run && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= eff;
    end else if (!run) begin
      cnt <= eff;
    end else if (tick || upd_load) begin
      cnt <= eff;
    end else begin
      cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/fsweep_accum.sv
module fsweep_accum
  import fsweep_pkg::*;
#(
  parameter int TW_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            run,
  input  logic            tick,
  input  logic            up,
  input  logic            no_dwell,
  input  logic            auto_zero,
  input  logic [TW_W-1:0] start_w,
  input  logic [TW_W-1:0] end_w,
  input  logic [TW_W-1:0] delta_w,
  output logic [TW_W-1:0] acc_next,
  output logic            wrap,
  output logic            at_end
);
  localparam int SUM_W = TW_W + 1;

  logic [TW_W-1:0]  acc;
  logic [TW_W-1:0]  span;
  logic [SUM_W-1:0] sum;
  acc_op_e          op;

  assign span = (end_w >= start_w) ? (end_w - start_w) : '0;
  assign sum  = {1'b0, acc} + {1'b0, delta_w};

  always_comb begin
    op = ACC_HOLD;
    if (clr || !run || auto_zero) begin
      op = ACC_ZERO;
    end else if (tick) begin
      if (up) begin
        if (sum >= {1'b0, span}) begin
          op = no_dwell ? ACC_WRAP : ACC_SAT;
        end else begin
          op = ACC_ADD;
        end
      end else begin
        op = ACC_SUB;
      end
    end
  end

  always_comb begin
    acc_next = acc;
    wrap     = 1'b0;
    unique case (op)
      ACC_ZERO: acc_next = '0;
      ACC_ADD:  acc_next = sum[TW_W-1:0];
      ACC_SAT:  acc_next = span;
      ACC_WRAP: begin
        acc_next = '0;
        wrap     = 1'b1;
      end
      ACC_SUB:  acc_next = (acc >= delta_w) ? (acc - delta_w) : '0;
      default:  acc_next = acc;
    endcase
  end

  assign at_end = (acc_next == span);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      acc <= '0;
    end else if (rst) begin
      acc <= '0;
    end else begin
      acc <= acc_next;
    end
  end
endmodule

// File: rtl/fsweep_gen.sv
module fsweep_gen #(
  parameter int TW_W = 32,
  parameter int RR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_clr,
  input  logic [TW_W-1:0] start_word,
  input  logic [TW_W-1:0] end_word,
  input  logic [TW_W-1:0] delta_word,
  input  logic [RR_W-1:0] rate_reload,
  input  logic            sweep_en,
  input  logic            no_dwell,
  input  logic            load_on_upd,
  input  logic            autoclr,
  input  logic            sweep_up,
  input  logic            upd,
  output logic [TW_W-1:0] ftw,
  output logic            done
);
  logic            tick;
  logic [TW_W-1:0] acc_next;
  logic            wrap;
  logic            at_end;
  logic            tmr_load;
  logic            zero_now;

  assign tmr_load = upd && load_on_upd;
  assign zero_now = upd && autoclr;

  fsweep_rate_timer #(.RR_W(RR_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run        (sweep_en),
    .reload_val (rate_reload),
    .upd_load   (tmr_load),
    .tick       (tick)
  );

  fsweep_accum #(.TW_W(TW_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clr       (acc_clr),
    .run       (sweep_en),
    .tick      (tick),
    .up        (sweep_up),
    .no_dwell  (no_dwell),
    .auto_zero (zero_now),
    .start_w   (start_word),
    .end_w     (end_word),
    .delta_w   (delta_word),
    .acc_next  (acc_next),
    .wrap      (wrap),
    .at_end    (at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw  <= '0;
      done <= 1'b0;
    end else if (!sweep_en) begin
      ftw  <= start_word;
      done <= 1'b0;
    end else begin
      ftw  <= start_word + acc_next;
      done <= !acc_clr && (wrap || (!no_dwell && sweep_up && at_end));
    end
  end
endmodule

// File: rtl/fsweep_gen_chk.sv
module fsweep_gen_chk #(
  parameter int TW_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            acc_clr,
  input logic            sweep_en,
  input logic            no_dwell,
  input logic [TW_W-1:0] start_word,
  input logic [TW_W-1:0] end_word,
  input logic [TW_W-1:0] ftw,
  input logic            done
);
  // R2: disabled sweep shows the start word
  a_r2_idle_start: assert property (@(posedge clk) disable iff (rst)
    $past(!sweep_en) |-> ftw == $past(start_word));

  // R10: clear forces the start word
  a_r10_clear_start: assert property (@(posedge clk) disable iff (rst)
    $past(acc_clr) |-> ftw == $past(start_word));

  // R5: in dwell mode a done flag means the end word is shown
  a_r5_dwell_end: assert property (@(posedge clk) disable iff (rst)
    (done && $past(sweep_en) && !$past(no_dwell)) |-> ftw == $past(end_word));

  // R6: in no-dwell mode a done flag means the start word is shown
  a_r6_wrap_start: assert property (@(posedge clk) disable iff (rst)
    (done && $past(sweep_en) && $past(no_dwell)) |-> ftw == $past(start_word));

  // R12: the output never leaves the start..end range
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ($past(sweep_en) && !$past(rst) && ($past(end_word) >= $past(start_word)))
      |-> (ftw >= $past(start_word) && ftw <= $past(end_word)));
endmodule

bind fsweep_gen fsweep_gen_chk #(.TW_W(TW_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_clr    (acc_clr),
  .sweep_en   (sweep_en),
  .no_dwell   (no_dwell),
  .start_word (start_word),
  .end_word   (end_word),
  .ftw        (ftw),
  .done       (done)
);

// File: tb/fsweep_gen_test.sv
module fsweep_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_clr = 1'b0;
  logic [31:0] start_word = '0;
  logic [31:0] end_word = '0;
  logic [31:0] delta_word = '0;
  logic [7:0]  rate_reload = 8'd1;
  logic        sweep_en = 1'b0;
  logic        no_dwell = 1'b0;
  logic        load_on_upd = 1'b0;
  logic        autoclr = 1'b0;
  logic        sweep_up = 1'b1;
  logic        upd = 1'b0;
  logic [31:0] ftw;
  logic        done;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fsweep_gen uut (
    .clk(clk), .rst(rst), .acc_clr(acc_clr), .start_word(start_word),
    .end_word(end_word), .delta_word(delta_word), .rate_reload(rate_reload),
    .sweep_en(sweep_en), .no_dwell(no_dwell), .load_on_upd(load_on_upd),
    .autoclr(autoclr), .sweep_up(sweep_up), .upd(upd), .ftw(ftw), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step1;
    @(posedge clk);
    #1;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] e,
                       input logic [31:0] d, input logic [7:0] r, input logic nd);
    sweep_en = 1'b0; load_on_upd = 1'b0; autoclr = 1'b0; upd = 1'b0;
    acc_clr = 1'b0; sweep_up = 1'b1; no_dwell = nd;
    start_word = s; end_word = e; delta_word = d; rate_reload = r;
    step1();
    step1();
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step1(); step1();
    chk("R1 ftw", ftw, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_disabled;
    setup(32'd100, 32'd200, 32'd5, 8'd1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      step1();
      chk("R2 ftw", ftw, 32'd100);
      chk("R2 done", {31'd0, done}, 32'd0);
    end
  endtask

  task automatic t_period;
    setup(32'd1000, 32'd2000, 32'd10, 8'd4, 1'b0);
    sweep_en = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      step1();
      chk("R3 step schedule", ftw, 32'd1000 + 32'd10 * 32'(k / 4));
    end
  endtask

  task automatic t_rate0;
    setup(32'd1000, 32'd2000, 32'd10, 8'd0, 1'b0);
    sweep_en = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      step1();
      chk("R4 rate zero", ftw, 32'd1000 + 32'd10 * 32'(k));
    end
  endtask

  task automatic t_dwell;
    logic [31:0] ef [5] = '{32'd10, 32'd20, 32'd30, 32'd35, 32'd35};
    logic        ed [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    setup(32'd0, 32'd35, 32'd10, 8'd1, 1'b0);
    sweep_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step1();
      chk("R5 dwell ftw", ftw, ef[k]);
      chk("R5 dwell done", {31'd0, done}, {31'd0, ed[k]});
    end
  endtask

  task automatic t_nodwell;
    logic [31:0] ef [5] = '{32'd10, 32'd20, 32'd30, 32'd0, 32'd10};
    logic        ed [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    setup(32'd0, 32'd35, 32'd10, 8'd1, 1'b1);
    sweep_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step1();
      chk("R6 no-dwell ftw", ftw, ef[k]);
      chk("R6 no-dwell done", {31'd0, done}, {31'd0, ed[k]});
    end
  endtask

  task automatic t_wide;
    setup(32'hFFFF_FF00, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 8'd1, 1'b0);
    sweep_en = 1'b1;
    step1();
    chk("R12 saturate", ftw, 32'hFFFF_FFF0);
    step1();
    chk("R12 hold", ftw, 32'hFFFF_FFF0);
  endtask

  task automatic t_upd_noload;
    setup(32'd500, 32'd900, 32'd7, 8'd4, 1'b0);
    sweep_en = 1'b1;
    step1(); step1();
    upd = 1'b1;
    step1();
    upd = 1'b0;
    chk("R7 edge3", ftw, 32'd500);
    step1();
    chk("R7 edge4 step", ftw, 32'd507);
    for (int k = 5; k <= 8; k++) step1();
    chk("R7 edge8 step", ftw, 32'd514);
  endtask

  task automatic t_upd_load;
    setup(32'd500, 32'd900, 32'd7, 8'd4, 1'b0);
    load_on_upd = 1'b1;
    sweep_en = 1'b1;
    step1(); step1();
    upd = 1'b1;
    step1();
    upd = 1'b0;
    step1();
    chk("R8 edge4 no step", ftw, 32'd500);
    step1(); step1();
    chk("R8 edge6 no step", ftw, 32'd500);
    step1();
    chk("R8 edge7 step", ftw, 32'd507);
    for (int k = 8; k <= 11; k++) step1();
    chk("R8 edge11 step", ftw, 32'd514);
    load_on_upd = 1'b0;
  endtask

  task automatic t_autoclr;
    setup(32'd0, 32'd1000, 32'd10, 8'd1, 1'b0);
    sweep_en = 1'b1;
    step1(); step1(); step1();
    chk("R9 pre", ftw, 32'd30);
    autoclr = 1'b1; upd = 1'b1;
    step1();
    upd = 1'b0;
    chk("R9 autoclear", ftw, 32'd0);
    step1();
    chk("R9 resume", ftw, 32'd10);
    autoclr = 1'b0; upd = 1'b1;
    step1();
    upd = 1'b0;
    chk("R9 strobe ignored", ftw, 32'd20);
  endtask

  task automatic t_clear;
    setup(32'd0, 32'd1000, 32'd10, 8'd1, 1'b0);
    sweep_en = 1'b1;
    step1(); step1(); step1();
    chk("R10 pre", ftw, 32'd30);
    acc_clr = 1'b1;
    step1();
    chk("R10 cleared", ftw, 32'd0);
    step1();
    chk("R10 held", ftw, 32'd0);
    acc_clr = 1'b0;
    step1();
    chk("R10 released", ftw, 32'd10);
  endtask

  task automatic t_down;
    logic [31:0] ef [4] = '{32'd20, 32'd10, 32'd0, 32'd0};
    setup(32'd0, 32'd1000, 32'd10, 8'd1, 1'b0);
    sweep_en = 1'b1;
    step1(); step1(); step1();
    sweep_up = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step1();
      chk("R11 down", ftw, ef[k]);
    end
    sweep_up = 1'b1;
  endtask

  initial begin
    #(2_000_000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_period();
    t_rate0();
    t_dwell();
    t_nodwell();
    t_wide();
    t_upd_noload();
    t_upd_load();
    t_autoclr();
    t_clear();
    t_down();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule